// File: doc/BRIEF.md
# Bridge Error Response and Status Logging Unit

This unit sits beside the datapath of a bridge between a PCI bus and a system expander link. The datapath reports each error it sees as a single-cycle event pulse. The events cover three kinds of error:

- parity errors on expander headers, on expander write data and on inbound read data;
- a parity error on outbound read data returned by a card, and a card driving its parity-error line;
- master aborts, target aborts, and a hard-fail completion of a peer-to-peer read.

For each event the unit decides the system response and drives it as a set of one-cycle decision pulses. The possible responses are: bus-init, system error, parity error, request drop, data poisoning, parity repair, all-ones read data, normal completion, hard-fail return, burst discard, and target abort toward the card.

The unit also records what happened in two sticky status registers. Software clears these by writing ones.

A mode input selects between outbound error handling and the legacy signalling path. With outbound handling on, expander parity errors become bus-init or poisoned data. With it off, they become a system-error pulse, and the data passes as good. A separate escalation input decides whether parity errors detected on the PCI side are also raised as a system error.

Top module: `brg_err_resp`

## Requirements
- R1: An expander header parity event (`ev_hdr_par`) sets bus status bit 0 (signalled system error) and error status bit 2, and pulses `drop_req_o`. With `ob_err_en`=1 it pulses `binit_o` and not `serr_o`. With `ob_err_en`=0 it pulses `serr_o` and not `binit_o`.
- R2: A write-data parity event (`ev_wdat_par`) or an inbound read-data parity event (`ev_ibrd_par`) sets bus status bit 0 and error status bit 2. With `ob_err_en`=1 it pulses `poison_o` and not `serr_o`. With `ob_err_en`=0 it pulses `serr_o` and not `poison_o`.
- R3: An outbound read-data parity event (`ev_obrd_par`) has these effects:
  - It pulses `perr_o` and `fix_par_o`.
  - It sets bus status bit 1 (parity error), bus status bit 2 (detected parity error) and error status bit 5.
  - Only when `perr_esc_en`=1, it also pulses `serr_o` and sets bus status bit 0.
- R4: A card parity-error event (`ev_card_perr`) sets error status bit 6 and bus status bit 2. Only when `perr_esc_en`=1, it pulses `serr_o` and sets bus status bit 0.
- R5: A master abort on a read (`ev_mab_rd`) pulses `ones_o`. A master abort on a write (`ev_mab_wr`) pulses `norm_cmp_o`. Either one sets bus status bit 3.
- R6: A received target abort (`ev_tab`) pulses `hard_fail_o` and sets bus status bit 4. `burst_drop_o` also pulses only when `ev_tab_mid` is high in the same cycle.
- R7: A peer-to-peer hard-fail read completion (`ev_p2p_hf`) pulses `tab_card_o` and sets bus status bit 5.
- R8: Every decision output is a one-cycle pulse that is high exactly in the cycle after its event.
- R9: Events in the same cycle set all of their status bits, and the decision outputs are the OR of their individual responses.
- R10: Status bits are sticky. A write (`csr_wr`=1) with `csr_sel`=0 addresses bus status, and `csr_sel`=1 addresses error status. A 1 in `csr_wdata` clears the bit, and a 0 leaves it unchanged.
- R11: When an event sets a status bit in the same cycle that a write clears it, the bit ends set.
- R12: After reset, all status bits and all decision outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ob_err_en | input | 1 | Outbound error handling mode |
| perr_esc_en | input | 1 | Escalate PCI-side parity errors to system error |
| ev_hdr_par | input | 1 | Expander header parity error event |
| ev_wdat_par | input | 1 | Expander write data parity error event |
| ev_ibrd_par | input | 1 | Inbound read data parity error event |
| ev_obrd_par | input | 1 | Outbound read data parity error from card |
| ev_mab_rd | input | 1 | Master abort on a read |
| ev_mab_wr | input | 1 | Master abort on a write |
| ev_tab | input | 1 | Target abort received |
| ev_tab_mid | input | 1 | Qualifier: target abort came partway through a burst |
| ev_card_perr | input | 1 | Card drove its parity-error line |
| ev_p2p_hf | input | 1 | Hard-fail read completion in peer-to-peer transfer |
| csr_wr | input | 1 | Status write strobe |
| csr_sel | input | 1 | 0 = bus status, 1 = error status |
| csr_wdata | input | 8 | Write-one-to-clear mask |
| pci_sts_o | output | 8 | Bus status register |
| err_sts_o | output | 8 | Error status register |
| serr_o | output | 1 | System error pulse |
| perr_o | output | 1 | Parity error pulse |
| binit_o | output | 1 | Fatal bus-init pulse |
| drop_req_o | output | 1 | Drop the request, no completion |
| poison_o | output | 1 | Forward data marked poisoned |
| fix_par_o | output | 1 | Forward data with regenerated good parity |
| ones_o | output | 1 | Return all-ones read data |
| norm_cmp_o | output | 1 | Discard write, return normal completion |
| hard_fail_o | output | 1 | Return hard-fail response |
| burst_drop_o | output | 1 | Discard remainder of the burst |
| tab_card_o | output | 1 | Target abort the read back to the card |

## Verification
Each event type is fired on its own under both settings of the mode input. This separates the bus-init and poisoning path from the system-error path. The outbound and card parity events are fired with escalation both off and on, to show that the system-error pulse and its status bit depend only on that input.

A mixed burst of events in one cycle tells an OR of responses apart from a priority encoding. The target abort is tried with and without its mid-burst qualifier.

Status writes use partial masks to separate a clear-by-one from a plain write. A write that lands in the same cycle as a setting event shows which of the two wins. The cycle after each event confirms that every decision output falls back to 0.

// File: rtl/brg_err_pkg.sv
package brg_err_pkg;

  localparam int NUM_EV = 10;
  localparam int STS_W  = 8;

  // event vector positions
  localparam int EV_HDR  = 0;
  localparam int EV_WDAT = 1;
  localparam int EV_IBRD = 2;
  localparam int EV_OBRD = 3;
  localparam int EV_MARD = 4;
  localparam int EV_MAWR = 5;
  localparam int EV_TAB  = 6;
  localparam int EV_TMID = 7;
  localparam int EV_PERR = 8;
  localparam int EV_P2P  = 9;

  // bus status bit positions
  localparam int PS_SSE = 0;
  localparam int PS_PE  = 1;
  localparam int PS_DPE = 2;
  localparam int PS_RMA = 3;
  localparam int PS_RTA = 4;
  localparam int PS_STA = 5;

  // error status bit positions
  localparam int ES_XPAR = 2;
  localparam int ES_OBRD = 5;
  localparam int ES_CARD = 6;

  typedef logic [NUM_EV-1:0] ev_vec_t;

  typedef struct packed {
    logic serr;
    logic perr;
    logic binit;
    logic drop_req;
    logic poison;
    logic fix_par;
    logic ones;
    logic norm_cmp;
    logic hard_fail;
    logic burst_drop;
    logic tab_card;
  } resp_t;

  function automatic logic f_xpar(input ev_vec_t ev);
    return ev[EV_HDR] | ev[EV_WDAT] | ev[EV_IBRD];
  endfunction

  function automatic logic f_esc_serr(input ev_vec_t ev, input logic esc);
    return esc & (ev[EV_OBRD] | ev[EV_PERR]);
  endfunction

  function automatic resp_t f_resp(input ev_vec_t ev, input logic ob, input logic esc);
    resp_t r;
    r.serr       = (f_xpar(ev) & ~ob) | f_esc_serr(ev, esc);
    r.perr       = ev[EV_OBRD];
    r.binit      = ev[EV_HDR] & ob;
    r.drop_req   = ev[EV_HDR];
    r.poison     = (ev[EV_WDAT] | ev[EV_IBRD]) & ob;
    r.fix_par    = ev[EV_OBRD];
    r.ones       = ev[EV_MARD];
    r.norm_cmp   = ev[EV_MAWR];
    r.hard_fail  = ev[EV_TAB];
    r.burst_drop = ev[EV_TAB] & ev[EV_TMID];
    r.tab_card   = ev[EV_P2P];
    return r;
  endfunction

  function automatic logic [STS_W-1:0] f_pci_set(input ev_vec_t ev, input logic esc);
    logic [STS_W-1:0] s;
    s         = '0;
    s[PS_SSE] = f_xpar(ev) | f_esc_serr(ev, esc);
    s[PS_PE]  = ev[EV_OBRD];
    s[PS_DPE] = ev[EV_OBRD] | ev[EV_PERR];
    s[PS_RMA] = ev[EV_MARD] | ev[EV_MAWR];
    s[PS_RTA] = ev[EV_TAB];
    s[PS_STA] = ev[EV_P2P];
    return s;
  endfunction

  function automatic logic [STS_W-1:0] f_err_set(input ev_vec_t ev);
    logic [STS_W-1:0] s;
    s          = '0;
    s[ES_XPAR] = f_xpar(ev);
    s[ES_OBRD] = ev[EV_OBRD];
    s[ES_CARD] = ev[EV_PERR];
    return s;
  endfunction

endpackage

// File: rtl/brg_err_decode.sv
module brg_err_decode
  import brg_err_pkg::*;
(
  input  ev_vec_t           ev,
  input  logic              ob,
  input  logic              esc,
  output resp_t             resp,
  output logic [STS_W-1:0]  pci_set,
  output logic [STS_W-1:0]  err_set
);
  always_comb begin
    resp    = f_resp(ev, ob, esc);
    pci_set = f_pci_set(ev, esc);
    err_set = f_err_set(ev);
  end
endmodule

// File: rtl/brg_err_sticky.sv
module brg_err_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[i] <= 1'b0;
      else if (set_i[i])
        q[i] <= 1'b1;
      else if (clr_en && clr_mask[i])
        q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/brg_err_pulse.sv
module brg_err_pulse
  import brg_err_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  resp_t d,
  output resp_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/brg_err_resp.sv
module brg_err_resp
  import brg_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ob_err_en,
  input  logic             perr_esc_en,
  input  logic             ev_hdr_par,
  input  logic             ev_wdat_par,
  input  logic             ev_ibrd_par,
  input  logic             ev_obrd_par,
  input  logic             ev_mab_rd,
  input  logic             ev_mab_wr,
  input  logic             ev_tab,
  input  logic             ev_tab_mid,
  input  logic             ev_card_perr,
  input  logic             ev_p2p_hf,
  input  logic             csr_wr,
  input  logic             csr_sel,
  input  logic [STS_W-1:0] csr_wdata,
  output logic [STS_W-1:0] pci_sts_o,
  output logic [STS_W-1:0] err_sts_o,
  output logic             serr_o,
  output logic             perr_o,
  output logic             binit_o,
  output logic             drop_req_o,
  output logic             poison_o,
  output logic             fix_par_o,
  output logic             ones_o,
  output logic             norm_cmp_o,
  output logic             hard_fail_o,
  output logic             burst_drop_o,
  output logic             tab_card_o
);
  ev_vec_t          ev;
  resp_t            resp_d;
  resp_t            resp_q;
  logic [STS_W-1:0] pci_set;
  logic [STS_W-1:0] err_set;
  logic             pci_clr_en;
  logic             err_clr_en;

  always_comb begin
    ev          = '0;
    ev[EV_HDR]  = ev_hdr_par;
    ev[EV_WDAT] = ev_wdat_par;
    ev[EV_IBRD] = ev_ibrd_par;
    ev[EV_OBRD] = ev_obrd_par;
    ev[EV_MARD] = ev_mab_rd;
    ev[EV_MAWR] = ev_mab_wr;
    ev[EV_TAB]  = ev_tab;
    ev[EV_TMID] = ev_tab_mid;
    ev[EV_PERR] = ev_card_perr;
    ev[EV_P2P]  = ev_p2p_hf;
  end

  assign pci_clr_en = csr_wr & ~csr_sel;
  assign err_clr_en = csr_wr &  csr_sel;

  brg_err_decode u_dec (
    .ev      (ev),
    .ob      (ob_err_en),
    .esc     (perr_esc_en),
    .resp    (resp_d),
    .pci_set (pci_set),
    .err_set (err_set)
  );

  brg_err_pulse u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (resp_d),
    .q     (resp_q)
  );

  brg_err_sticky #(.W(STS_W)) u_pci_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (pci_set),
    .clr_en   (pci_clr_en),
    .clr_mask (csr_wdata),
    .q        (pci_sts_o)
  );

  brg_err_sticky #(.W(STS_W)) u_err_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (err_set),
    .clr_en   (err_clr_en),
    .clr_mask (csr_wdata),
    .q        (err_sts_o)
  );

  assign serr_o       = resp_q.serr;
  assign perr_o       = resp_q.perr;
  assign binit_o      = resp_q.binit;
  assign drop_req_o   = resp_q.drop_req;
  assign poison_o     = resp_q.poison;
  assign fix_par_o    = resp_q.fix_par;
  assign ones_o       = resp_q.ones;
  assign norm_cmp_o   = resp_q.norm_cmp;
  assign hard_fail_o  = resp_q.hard_fail;
  assign burst_drop_o = resp_q.burst_drop;
  assign tab_card_o   = resp_q.tab_card;
endmodule

// File: rtl/brg_err_resp_chk.sv
module brg_err_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ob_err_en,
  input logic       ev_hdr_par,
  input logic       ev_wdat_par,
  input logic       ev_ibrd_par,
  input logic       ev_obrd_par,
  input logic       ev_mab_rd,
  input logic       ev_tab,
  input logic       csr_wr,
  input logic       csr_sel,
  input logic [7:0] pci_sts_o,
  input logic       serr_o,
  input logic       perr_o,
  input logic       binit_o,
  input logic       poison_o,
  input logic       ones_o,
  input logic       hard_fail_o
);
  assert_binit_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    binit_o |-> ($past(ev_hdr_par) && $past(ob_err_en)));

  assert_hdr_legacy_serr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hdr_par && !ob_err_en) |=> (serr_o && !binit_o));

  assert_poison_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    poison_o |-> ($past(ob_err_en) && ($past(ev_wdat_par) || $past(ev_ibrd_par))));

  assert_obrd_perr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_obrd_par |=> perr_o);

  assert_perr_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    perr_o |-> $past(ev_obrd_par));

  assert_mab_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mab_rd |=> ones_o);

  assert_tab_hf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tab |=> hard_fail_o);

  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_fail_o && !ev_tab) |=> !hard_fail_o);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_wr && !csr_sel) |=> ((pci_sts_o & $past(pci_sts_o)) == $past(pci_sts_o)));
endmodule

bind brg_err_resp brg_err_resp_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ob_err_en   (ob_err_en),
  .ev_hdr_par  (ev_hdr_par),
  .ev_wdat_par (ev_wdat_par),
  .ev_ibrd_par (ev_ibrd_par),
  .ev_obrd_par (ev_obrd_par),
  .ev_mab_rd   (ev_mab_rd),
  .ev_tab      (ev_tab),
  .csr_wr      (csr_wr),
  .csr_sel     (csr_sel),
  .pci_sts_o   (pci_sts_o),
  .serr_o      (serr_o),
  .perr_o      (perr_o),
  .binit_o     (binit_o),
  .poison_o    (poison_o),
  .ones_o      (ones_o),
  .hard_fail_o (hard_fail_o)
);

// File: tb/brg_err_resp_bench.sv
module brg_err_resp_bench;
  localparam int CLK_P = 10;

  // event bits in bench vector
  localparam logic [9:0] E_HDR = 10'h001, E_WDAT = 10'h002, E_IBRD = 10'h004,
                         E_OBRD = 10'h008, E_MARD = 10'h010, E_MAWR = 10'h020,
                         E_TAB = 10'h040, E_TMID = 10'h080, E_PERR = 10'h100,
                         E_P2P = 10'h200;
  // response bits in bench vector
  localparam logic [10:0] O_SERR = 11'h400, O_PERR = 11'h200, O_BINIT = 11'h100,
                          O_DROP = 11'h080, O_POIS = 11'h040, O_FIX = 11'h020,
                          O_ONES = 11'h010, O_NCMP = 11'h008, O_HF = 11'h004,
                          O_BDROP = 11'h002, O_TABC = 11'h001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ob_err_en = 1'b0, perr_esc_en = 1'b0;
  logic [9:0] ev = '0;
  logic csr_wr = 1'b0, csr_sel = 1'b0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] pci_sts_o, err_sts_o;
  logic serr_o, perr_o, binit_o, drop_req_o, poison_o, fix_par_o, ones_o;
  logic norm_cmp_o, hard_fail_o, burst_drop_o, tab_card_o;
  logic [10:0] resp;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign resp = {serr_o, perr_o, binit_o, drop_req_o, poison_o, fix_par_o,
                 ones_o, norm_cmp_o, hard_fail_o, burst_drop_o, tab_card_o};

  brg_err_resp u_brg_err_resp (
    .clk(clk), .rst_n(rst_n), .ob_err_en(ob_err_en), .perr_esc_en(perr_esc_en),
    .ev_hdr_par(ev[0]), .ev_wdat_par(ev[1]), .ev_ibrd_par(ev[2]), .ev_obrd_par(ev[3]),
    .ev_mab_rd(ev[4]), .ev_mab_wr(ev[5]), .ev_tab(ev[6]), .ev_tab_mid(ev[7]),
    .ev_card_perr(ev[8]), .ev_p2p_hf(ev[9]),
    .csr_wr(csr_wr), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .pci_sts_o(pci_sts_o), .err_sts_o(err_sts_o),
    .serr_o(serr_o), .perr_o(perr_o), .binit_o(binit_o), .drop_req_o(drop_req_o),
    .poison_o(poison_o), .fix_par_o(fix_par_o), .ones_o(ones_o),
    .norm_cmp_o(norm_cmp_o), .hard_fail_o(hard_fail_o),
    .burst_drop_o(burst_drop_o), .tab_card_o(tab_card_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); csr_wr = 1'b1; csr_sel = 1'b0; csr_wdata = 8'hFF;
    @(negedge clk); csr_sel = 1'b1;
    @(negedge clk); csr_wr = 1'b0; csr_wdata = 8'h00; csr_sel = 1'b0;
  endtask

  // one event pattern: fire, check response and status, check pulse falls
  task automatic scen(input string req, input logic [9:0] e, input logic ob,
                      input logic esc, input logic [10:0] er,
                      input logic [7:0] ep, input logic [7:0] ee);
    clear_all();
    ob_err_en = ob; perr_esc_en = esc; ev = e;
    @(negedge clk); ev = '0;
    check(req, "response", resp, er);
    check(req, "bus status", pci_sts_o, ep);
    check(req, "error status", err_sts_o, ee);
    @(negedge clk);
    check("R8", {req, " pulse end"}, resp, 11'h0);
    check("R10", {req, " sticky"}, pci_sts_o, ep);
  endtask

  task automatic t_reset();
    check("R12", "reset response", resp, 11'h0);
    check("R12", "reset bus status", pci_sts_o, 8'h00);
    check("R12", "reset error status", err_sts_o, 8'h00);
  endtask

  task automatic t_w1c();
    clear_all();
    ev = E_OBRD | E_MARD | E_P2P | E_PERR; perr_esc_en = 1'b0;
    @(negedge clk); ev = '0;
    // bus: PE(1) DPE(2) RMA(3) STA(5) = 0x2E ; err: bits 5,6 = 0x60
    csr_wr = 1'b1; csr_sel = 1'b0; csr_wdata = 8'h08;
    @(negedge clk); csr_wr = 1'b0;
    check("R10", "clear RMA only", pci_sts_o, 8'h26);
    check("R10", "error status untouched", err_sts_o, 8'h60);
    csr_wr = 1'b1; csr_sel = 1'b1; csr_wdata = 8'h00;
    @(negedge clk);
    check("R10", "write zero no effect", err_sts_o, 8'h60);
    csr_wdata = 8'h40;
    @(negedge clk); csr_wr = 1'b0; csr_wdata = 8'h00;
    check("R10", "clear card bit", err_sts_o, 8'h20);
    check("R10", "bus status untouched", pci_sts_o, 8'h26);
  endtask

  task automatic t_set_wins();
    clear_all();
    ob_err_en = 1'b1;
    ev = E_HDR; csr_wr = 1'b1; csr_sel = 1'b0; csr_wdata = 8'hFF;
    @(negedge clk); ev = '0; csr_wr = 1'b0;
    check("R11", "set beats clear bus", pci_sts_o, 8'h01);
    ev = E_WDAT; csr_wr = 1'b1; csr_sel = 1'b1; csr_wdata = 8'hFF;
    @(negedge clk); ev = '0; csr_wr = 1'b0; csr_wdata = 8'h00;
    check("R11", "set beats clear err", err_sts_o, 8'h04);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    // R1 header parity
    scen("R1", E_HDR, 1'b1, 1'b0, O_BINIT | O_DROP, 8'h01, 8'h04);
    scen("R1", E_HDR, 1'b0, 1'b0, O_SERR | O_DROP, 8'h01, 8'h04);
    // R2 write data / inbound read parity
    scen("R2", E_WDAT, 1'b1, 1'b0, O_POIS, 8'h01, 8'h04);
    scen("R2", E_WDAT, 1'b0, 1'b0, O_SERR, 8'h01, 8'h04);
    scen("R2", E_IBRD, 1'b1, 1'b0, O_POIS, 8'h01, 8'h04);
    scen("R2", E_IBRD, 1'b0, 1'b0, O_SERR, 8'h01, 8'h04);
    // R3 outbound read parity
    scen("R3", E_OBRD, 1'b1, 1'b0, O_PERR | O_FIX, 8'h06, 8'h20);
    scen("R3", E_OBRD, 1'b1, 1'b1, O_SERR | O_PERR | O_FIX, 8'h07, 8'h20);
    // R4 card parity
    scen("R4", E_PERR, 1'b0, 1'b0, 11'h0, 8'h04, 8'h40);
    scen("R4", E_PERR, 1'b0, 1'b1, O_SERR, 8'h05, 8'h40);
    // R5 master abort
    scen("R5", E_MARD, 1'b0, 1'b0, O_ONES, 8'h08, 8'h00);
    scen("R5", E_MAWR, 1'b0, 1'b0, O_NCMP, 8'h08, 8'h00);
    // R6 target abort
    scen("R6", E_TAB, 1'b0, 1'b0, O_HF, 8'h10, 8'h00);
    scen("R6", E_TAB | E_TMID, 1'b0, 1'b0, O_HF | O_BDROP, 8'h10, 8'h00);
    scen("R6", E_TMID, 1'b0, 1'b0, 11'h0, 8'h00, 8'h00);
    // R7 peer-to-peer hard fail
    scen("R7", E_P2P, 1'b0, 1'b0, O_TABC, 8'h20, 8'h00);
    // R9 simultaneous events
    scen("R9", E_HDR | E_WDAT | E_MAWR | E_P2P, 1'b1, 1'b0,
         O_BINIT | O_DROP | O_POIS | O_NCMP | O_TABC, 8'h29, 8'h04);
    scen("R9", E_IBRD | E_OBRD | E_TAB | E_TMID | E_MARD, 1'b0, 1'b0,
         O_SERR | O_PERR | O_FIX | O_ONES | O_HF | O_BDROP, 8'h1F, 8'h24);
    t_w1c();
    t_set_wins();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule